// File: doc/BRIEF.md
# Flash Block Write-Protection Manager

This block keeps a protection state for every erase block of a flash array with a configurable number of blocks. Each block is in one of three states: unlocked, locked or lock-tight. Software first writes a range start block and a range end block. It then issues one of four commands: unlock a range, unlock every block, lock a range, or lock-tight a range. The block then steps through the chosen blocks at one block per clock. It applies the transition rules, in which lock-tight blocks resist every change until the next reset.

A program or erase path asks about any block through a combinational query port. Software sees the outcome in three places: a write-protection status value that holds the last state written by a walk, a command-error flag, and a one-cycle done strobe. The start and end block registers can be read back.

Top module: `blk_lock_mgr`

## Requirements
- R1: After reset every block reads locked, wp_status is 3'b010, busy, done and cmd_err are 0, and both range registers are 0. State encodings are: lock-tight 3'b001, locked 3'b010, unlocked 3'b100.
- R2: A start write stores addr_wdata masked to its low IW bits into both start_q and end_q. An end write stores the masked value into end_q only.
- R3: Command 8'h23 sets blocks start_q through end_q (inclusive, ascending) to unlocked. It stops at the first lock-tight block and leaves that block unchanged.
- R4: Command 8'h27 sets blocks from 0 up to NUM_BLOCKS-1 to unlocked. It stops at the first lock-tight block and leaves that block unchanged.
- R5: Command 8'h2A sets blocks start_q through end_q to locked. It stops at the first lock-tight block and leaves that block unchanged.
- R6: Command 8'h2C sets every block from start_q through end_q to lock-tight, except unlocked blocks, which it passes over unchanged.
- R7: When a range walk reaches an index at or above NUM_BLOCKS, cmd_err becomes 1 and the walk ends. cmd_err clears when the next command is accepted.
- R8: Each block a walk writes also loads its new state into wp_status. A walk that writes nothing leaves wp_status unchanged.
- R9: A walk handles one index per clock. busy stays high for one cycle per index visited, counting the index that stops the walk, or for one cycle when start_q > end_q (nothing changes then). done pulses for exactly one cycle as busy falls.
- R10: A command that arrives while busy, or an unknown command code, has no effect.
- R11: A lock-tight block stays lock-tight until reset. query_state returns the state of block query_blk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, locks all blocks |
| start_wr | input | 1 | Write range start (also copies to end) |
| end_wr | input | 1 | Write range end |
| addr_wdata | input | ADDR_W | Block address write data |
| start_q | output | IW | Range start register |
| end_q | output | IW | Range end register |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| cmd_err | output | 1 | Walk ran past the last block |
| wp_status | output | 3 | Last state written by a walk |
| query_blk | input | IW | Block to query |
| query_state | output | 3 | State of the queried block |

## Verification
The hardest situation to reach is a walk that runs past the last real block. This needs an end index at or above NUM_BLOCKS, which only a non-power-of-two block count allows. The default of 24 blocks gives that gap, and a directed range of 20..27 drives into it. An early stop on a lock-tight block inside a range is also rare under random stimulus. Directed cases first tighten a single block and then walk across it. After that, seeded random commands over masked start and end values build up mixed states, and a bench model predicts the contents of every block, wp_status, cmd_err and the number of busy cycles.

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr #(
  parameter int NUM_BLOCKS = 24,
  parameter int ADDR_W     = 16,
  parameter int IW         = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              end_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  output logic [IW-1:0]     start_q,
  output logic [IW-1:0]     end_q,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  output logic              busy,
  output logic              done,
  output logic              cmd_err,
  output logic [2:0]        wp_status,
  input  logic [IW-1:0]     query_blk,
  output logic [2:0]        query_state
);
  localparam logic [2:0]  ST_TIGHT  = 3'b001;
  localparam logic [2:0]  ST_LOCKED = 3'b010;
  localparam logic [2:0]  ST_OPEN   = 3'b100;
  localparam logic [IW:0] NB        = (IW+1)'(NUM_BLOCKS);
  localparam logic [IW-1:0] LAST_BLK = IW'(NUM_BLOCKS - 1);

  logic [2:0]    tab [NUM_BLOCKS];
  logic [IW-1:0] idx, last;
  logic [2:0]    new_st;
  logic          tight_op;

  wire known     = (cmd_code == 8'h23) || (cmd_code == 8'h27) ||
                   (cmd_code == 8'h2A) || (cmd_code == 8'h2C);
  wire accept    = cmd_valid && !busy && known;
  wire in_range  = {1'b0, idx} < NB;
  wire [2:0] cur = in_range ? tab[idx] : 3'b000;
  wire past_end  = idx > last;
  wire stop_tgt  = !tight_op && (cur == ST_TIGHT);
  wire skip      = tight_op && (cur == ST_OPEN);
  wire wr_en     = busy && !past_end && in_range && !stop_tgt && !skip;
  wire finish    = busy && (past_end || !in_range || stop_tgt || idx == last);

  assign query_state = ({1'b0, query_blk} < NB) ? tab[query_blk] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
    end else begin
      if (start_wr) start_q <= addr_wdata[IW-1:0];
      if (start_wr || end_wr) end_q <= addr_wdata[IW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      cmd_err   <= 1'b0;
      idx       <= '0;
      last      <= '0;
      new_st    <= ST_LOCKED;
      tight_op  <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        busy     <= 1'b1;
        cmd_err  <= 1'b0;
        tight_op <= (cmd_code == 8'h2C);
        new_st   <= (cmd_code == 8'h2C) ? ST_TIGHT :
                    (cmd_code == 8'h2A) ? ST_LOCKED : ST_OPEN;
        idx      <= (cmd_code == 8'h27) ? '0 : start_q;
        last     <= (cmd_code == 8'h27) ? LAST_BLK : end_q;
      end else if (busy) begin
        if (finish) busy <= 1'b0;
        else        idx  <= idx + 1'b1;
        if (!past_end && !in_range) cmd_err <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_status <= ST_LOCKED;
      for (int i = 0; i < NUM_BLOCKS; i++) tab[i] <= ST_LOCKED;
    end else if (wr_en) begin
      wp_status <= new_st;
      tab[idx]  <= new_st;
    end
  end
endmodule

module blk_lock_mgr_chk #(
  parameter int NUM_BLOCKS = 24,
  parameter int ADDR_W     = 16,
  parameter int IW         = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_wr,
  input logic [ADDR_W-1:0] addr_wdata,
  input logic [IW-1:0]     start_q,
  input logic [IW-1:0]     end_q,
  input logic              busy,
  input logic              done,
  input logic              cmd_err,
  input logic [2:0]        wp_status,
  input logic [IW-1:0]     query_blk,
  input logic [2:0]        query_state
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_wp_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wp_status) == 1);
  p_query_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(query_blk) < NUM_BLOCKS) |-> $countones(query_state) == 1);
  p_tight_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (query_state == 3'b001) |=> (!$stable(query_blk) || query_state == 3'b001));
  p_end_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (end_q == start_q) && (start_q == $past(addr_wdata[IW-1:0])));
  p_err_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err) |-> done);
endmodule

bind blk_lock_mgr blk_lock_mgr_chk #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .addr_wdata(addr_wdata),
  .start_q(start_q), .end_q(end_q), .busy(busy), .done(done), .cmd_err(cmd_err),
  .wp_status(wp_status), .query_blk(query_blk), .query_state(query_state));

// File: tb/sim_blk_lock_mgr.sv
module sim_blk_lock_mgr;
  localparam int N  = 24;
  localparam int AW = 16;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_wr = 0, end_wr = 0, cmd_valid = 0;
  logic [AW-1:0] addr_wdata = '0;
  logic [7:0] cmd_code = '0;
  logic [IW-1:0] query_blk = '0;
  logic [IW-1:0] start_q, end_q;
  logic busy, done, cmd_err;
  logic [2:0] wp_status, query_state;

  always #10 clk = ~clk;

  blk_lock_mgr #(.NUM_BLOCKS(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .end_wr(end_wr),
    .addr_wdata(addr_wdata), .start_q(start_q), .end_q(end_q),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .busy(busy), .done(done),
    .cmd_err(cmd_err), .wp_status(wp_status), .query_blk(query_blk),
    .query_state(query_state));

  int checks = 0, fails = 0;
  logic [2:0] m_tab [N];
  logic [2:0] m_wp;
  logic m_err;
  int m_start, m_end, m_cyc;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_tab[i] = 3'b010;
    m_wp = 3'b010; m_err = 0; m_start = 0; m_end = 0;
  endtask

  task automatic model_cmd(input logic [7:0] c);
    int lo, hi; logic [2:0] nv;
    lo = m_start; hi = m_end; nv = 3'b100;
    if (c == 8'h27) begin lo = 0; hi = N - 1; end
    if (c == 8'h2A) nv = 3'b010;
    if (c == 8'h2C) nv = 3'b001;
    m_err = 0; m_cyc = 0;
    for (int b = lo; b <= hi; b++) begin
      m_cyc++;
      if (b >= N) begin m_err = 1; break; end
      if (c != 8'h2C && m_tab[b] == 3'b001) break;
      if (c == 8'h2C && m_tab[b] == 3'b100) continue;
      m_tab[b] = nv; m_wp = nv;
    end
    if (m_cyc == 0) m_cyc = 1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic wr_start(input int v);
    addr_wdata = AW'(v); start_wr = 1;
    @(negedge clk); start_wr = 0;
    m_start = v & ((1 << IW) - 1); m_end = m_start;
  endtask

  task automatic wr_end(input int v);
    addr_wdata = AW'(v); end_wr = 1;
    @(negedge clk); end_wr = 0;
    m_end = v & ((1 << IW) - 1);
  endtask

  task automatic cmp_state(input string tag);
    int bad; bad = -1;
    for (int b = 0; b < N; b++) begin
      query_blk = IW'(b); #1;
      if (bad < 0 && query_state !== m_tab[b]) bad = b;
    end
    if (bad >= 0) begin
      query_blk = IW'(bad); #1;
      chk(0, {tag, " block state"}, int'(query_state), int'(m_tab[bad]));
    end else chk(1, tag, 0, 0);
    chk(wp_status === m_wp, "R8 wp_status", int'(wp_status), int'(m_wp));
    chk(cmd_err === m_err, "R7 cmd_err", int'(cmd_err), int'(m_err));
  endtask

  task automatic issue(input logic [7:0] c, input string tag, input bit inject);
    int n; bit saw_done;
    cmd_code = c; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
    model_cmd(c);
    n = 0; saw_done = 0;
    while (busy === 1'b1 && n < 1000) begin
      if (done) saw_done = 1;
      if (inject && n == 0) begin cmd_code = 8'h2C; cmd_valid = 1; end
      n++;
      @(negedge clk);
      cmd_valid = 0;
    end
    chk(n == m_cyc, "R9 busy cycles", n, m_cyc);
    chk(done === 1'b1 && !saw_done, "R9 done at end", int'(done), 1);
    @(negedge clk);
    chk(done === 1'b0, "R9 done one cycle", int'(done), 0);
    cmp_state(tag);
  endtask

  initial begin
    #4000000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R1 reset state
    chk(busy === 0 && done === 0, "R1 busy/done", int'({busy, done}), 0);
    chk(start_q === 0 && end_q === 0, "R1 range regs", int'({start_q, end_q}), 0);
    cmp_state("R1 reset table");

    // R2 masking and copy
    wr_start(16'h00F3);
    chk(start_q == 19 && end_q == 19, "R2 start copy", int'({start_q, end_q}), {5'd19, 5'd19});
    wr_end(22);
    chk(start_q == 19 && end_q == 22, "R2 end only", int'({start_q, end_q}), {5'd19, 5'd22});

    // R5 lock range then R6 tighten a single block
    wr_start(10); wr_end(12); issue(8'h2A, "R5 lock range", 0);
    wr_start(5); issue(8'h2C, "R6 tighten one", 0);
    // R3 unlock across a tight block stops there
    wr_start(2); wr_end(8); issue(8'h23, "R3 unlock stop", 0);
    // R4 unlock all stops at block 5
    issue(8'h27, "R4 unlock all", 0);
    // R6 tighten range with unlocked blocks skipped
    wr_start(0); wr_end(9); issue(8'h2C, "R6 tight skip", 0);
    // R11 tight block survives unlock and lock
    wr_start(7); issue(8'h23, "R11 tight unlock", 0);
    issue(8'h2A, "R11 tight lock", 0);
    query_blk = 7; #1;
    chk(query_state === 3'b001, "R11 tight persists", int'(query_state), 1);
    // R7 walk past last block
    wr_start(20); wr_end(27); issue(8'h23, "R7 overrun", 0);
    chk(cmd_err === 1, "R7 err set", int'(cmd_err), 1);
    // R9 start > end: no change
    wr_start(15); wr_end(3); issue(8'h2A, "R9 empty range", 0);
    // R10 command while busy ignored
    wr_start(10); wr_end(19); issue(8'h23, "R10 busy ignore", 1);
    // R10 unknown code ignored
    begin
      bit any; any = 0;
      cmd_code = 8'h55; cmd_valid = 1; @(negedge clk); cmd_valid = 0;
      repeat (4) begin if (busy || done) any = 1; @(negedge clk); end
      chk(!any, "R10 unknown code", int'(any), 0);
      cmp_state("R10 unknown table");
    end

    // random phase
    for (int it = 0; it < 300; it++) begin
      logic [7:0] codes [4];
      codes[0] = 8'h23; codes[1] = 8'h27; codes[2] = 8'h2A; codes[3] = 8'h2C;
      if (it == 150) begin
        do_reset();
        cmp_state("R1 second reset");
      end
      wr_start(int'($urandom & 32'hFFFF));
      if ($urandom_range(0, 3) != 0) wr_end(int'($urandom & 32'hFFFF));
      issue(codes[$urandom_range(0, 3)], "R3 R4 R5 R6 random", 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule